// File: doc/BRIEF.md
# Packet-Tracking Transmit FIFO with Rewind

This block is the transmit buffer for one IN endpoint of a device-side USB controller. Software or a DMA engine pushes data words on the write side and flags the final word of each packet. It can also post a zero-length packet, which takes a slot in the packet queue but no data storage. The block records each finished packet's word count in a small descriptor queue. It reports how many complete packets are waiting, how many data words are free, and whether the packet at the head is zero-length.

The controller's transmit engine drives the read side. When an IN token arrives, it asks the block to open the head packet. The block presents that packet's length and zero-length status, and the engine then pulls the words one at a time. Once the host has handshaken the packet, the engine acknowledges it, and the packet's storage and queue slot are released. If the transfer fails (a timeout, or no handshake), the engine rewinds instead. The read pointer returns to the first word of the packet, which stays queued so it can be sent again on the next token.

Storage depth, word width and packet queue depth are parameters. The data store is a simple dual-port memory with a registered read, so it maps onto block RAM. The depth must be a power of two, and the queue depth must be at least two.

Top module: `txpkt_fifo`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `free_words` equals DEPTH, `pkt_count` is 0, and `overflow`, `active` and `rd_valid` are 0.
- R2: `pkt_count` increases by one in the cycle after an accepted write with `wr_last`=1. An accepted write with `wr_last`=0 changes `pkt_count` not at all but lowers `free_words` by one.
- R3: A `wr_zlp` pulse with `wr_valid` low queues a zero-length packet. It raises `pkt_count` by one, leaves `free_words` unchanged, and when that packet reaches the head `head_zlp` is 1. Opening it gives `cur_len`=0 and `cur_zlp`=1.
- R4: `in_token` opens the head packet (`active`=1, `cur_len` = its word count) only when `pkt_count` is nonzero and no packet is open. With nothing queued, `active` stays 0.
- R5: Each `rd_en` cycle while an open packet still has unread words yields the next word in write order on `rd_data`, with `rd_valid`=1, in the following cycle. `rd_en` after the last word of the open packet gives `rd_valid`=0.
- R6: `pkt_ack` with every word of the open packet read closes it (`active`=0), lowers `pkt_count` by one and raises `free_words` by the packet's length, all in the next cycle.
- R7: `pkt_ack` while words of the open packet remain unread has no effect: `active` stays 1 and `pkt_count` is unchanged.
- R8: `rewind` while a packet is open closes it without consuming it. `pkt_count` and `free_words` are unchanged, and the next `in_token` replays the same words from the first one. `rewind` wins over `pkt_ack` in the same cycle.
- R9: `pkt_count` never exceeds MAX_PKTS (8 by default). While MAX_PKTS packets are queued, every data write and zero-length write is dropped.
- R10: A write that finds no free word, or a full packet queue, is dropped and sets `overflow`. `overflow` stays 1 until reset.
- R11: `free_words` equals DEPTH minus all stored words, counting the words of a packet still being written and of the open packet until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Push one data word |
| wr_data | input | DW | Data word to push |
| wr_last | input | 1 | The pushed word ends its packet |
| wr_zlp | input | 1 | Queue a zero-length packet (only when wr_valid is low) |
| free_words | output | clog2(DEPTH+1) | Unused data words |
| pkt_count | output | clog2(MAX_PKTS+1) | Complete packets queued |
| head_zlp | output | 1 | Head packet is zero-length |
| overflow | output | 1 | Sticky: a write was dropped |
| in_token | input | 1 | IN token: open the head packet |
| rd_en | input | 1 | Pull the next word of the open packet |
| pkt_ack | input | 1 | Open packet consumed: release it |
| rewind | input | 1 | Abandon the open packet for retransmission |
| active | output | 1 | A packet is open for reading |
| cur_len | output | clog2(DEPTH+1) | Word count of the open packet |
| cur_zlp | output | 1 | Open packet is zero-length |
| rd_valid | output | 1 | rd_data holds a word pulled last cycle |
| rd_data | output | DW | Word read out |

## Verification
A read pointer left in the wrong place after a rewind or an acknowledge shows up on `rd_data` at the first word of the next token. It appears as data out of write order, one cycle after the first `rd_en`. A packet count or stored length that drifts shows up as a `cur_len` mismatch on the next token, or as a `pkt_count` step missing in the cycle after the write or acknowledge that should have caused it. A word count that is not released or not charged shows up at once in `free_words`. Later it shows up as writes dropped too early or accepted into a full store, which surfaces through `overflow`.

// File: rtl/txpkt_pkg.sv
package txpkt_pkg;
  // Read-side state: idle, or a packet opened by an IN token.
  typedef enum logic {
    RS_IDLE = 1'b0,
    RS_SEND = 1'b1
  } rd_state_e;
endpackage

// File: rtl/txpkt_ram.sv
// Simple dual-port memory with a registered read port (block-RAM style).
module txpkt_ram #(
  parameter int DW = 32,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int WORDS = 1 << AW;

  logic [DW-1:0] store [WORDS];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
    if (re) rdata <= store[raddr];
  end
endmodule

// File: rtl/txpkt_desc_q.sv
// Small queue of packet lengths, one entry per complete packet.
module txpkt_desc_q #(
  parameter int LW      = 6,
  parameter int ENTRIES = 8,
  parameter int CW      = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [LW-1:0] push_len,
  input  logic          pop,
  output logic [LW-1:0] head_len,
  output logic [CW-1:0] count
);
  localparam int IW = $clog2(ENTRIES);
  localparam logic [IW-1:0] LAST_IDX = IW'(ENTRIES - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(ENTRIES);

  logic [LW-1:0] lens [ENTRIES];
  logic [IW-1:0] wr_idx, rd_idx;
  logic          push_ok, pop_ok;

  assign push_ok  = push && (count != FULL_CNT);
  assign pop_ok   = pop && (count != '0);
  assign head_len = lens[rd_idx];

  always_ff @(posedge clk) begin
    if (push_ok) lens[wr_idx] <= push_len;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_idx <= '0;
      rd_idx <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_idx <= (wr_idx == LAST_IDX) ? '0 : wr_idx + IW'(1);
      if (pop_ok)  rd_idx <= (rd_idx == LAST_IDX) ? '0 : rd_idx + IW'(1);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/txpkt_rd_ctl.sv
// Read side: opens the head packet on a token, steps through its words,
// and either commits it (acknowledge) or returns to its first word (rewind).
module txpkt_rd_ctl #(
  parameter int AW = 5,
  parameter int LW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_token,
  input  logic          rd_en,
  input  logic          pkt_ack,
  input  logic          rewind,
  input  logic          have_pkt,
  input  logic [LW-1:0] head_len,
  output logic          active,
  output logic [LW-1:0] cur_len,
  output logic          cur_zlp,
  output logic          rd_valid,
  output logic          mem_re,
  output logic [AW-1:0] rd_ptr,
  output logic          ack_fire
);
  import txpkt_pkg::*;

  rd_state_e     state;
  logic [AW-1:0] base_ptr;
  logic [LW-1:0] remain;
  logic          tok_fire, rew_fire, pop_fire;

  assign active   = (state == RS_SEND);
  assign tok_fire = !active && in_token && have_pkt;
  assign rew_fire = active && rewind;
  assign pop_fire = active && !rewind && rd_en && (remain != '0);
  assign ack_fire = active && !rewind && pkt_ack && (remain == '0);
  assign mem_re   = pop_fire;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= RS_IDLE;
      base_ptr <= '0;
      rd_ptr   <= '0;
      remain   <= '0;
      cur_len  <= '0;
      cur_zlp  <= 1'b0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= pop_fire;
      if (tok_fire) begin
        state   <= RS_SEND;
        cur_len <= head_len;
        remain  <= head_len;
        cur_zlp <= (head_len == '0);
      end
      if (pop_fire) begin
        rd_ptr <= rd_ptr + AW'(1);
        remain <= remain - LW'(1);
      end
      if (rew_fire) begin
        state  <= RS_IDLE;
        rd_ptr <= base_ptr;
      end
      if (ack_fire) begin
        state    <= RS_IDLE;
        base_ptr <= rd_ptr;
      end
    end
  end
endmodule

// File: rtl/txpkt_fifo.sv
// Packet-tracking transmit FIFO for one IN endpoint.
module txpkt_fifo #(
  parameter int DW       = 32,
  parameter int DEPTH    = 32,
  parameter int MAX_PKTS = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = $clog2(DEPTH + 1),
  localparam int CW = $clog2(MAX_PKTS + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_valid,
  input  logic [DW-1:0] wr_data,
  input  logic          wr_last,
  input  logic          wr_zlp,
  output logic [LW-1:0] free_words,
  output logic [CW-1:0] pkt_count,
  output logic          head_zlp,
  output logic          overflow,
  input  logic          in_token,
  input  logic          rd_en,
  input  logic          pkt_ack,
  input  logic          rewind,
  output logic          active,
  output logic [LW-1:0] cur_len,
  output logic          cur_zlp,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data
);
  localparam logic [CW-1:0] MAX_CNT = CW'(MAX_PKTS);
  localparam logic [LW-1:0] FULL_W  = LW'(DEPTH);

  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [LW-1:0] used_q, part_q, head_len, push_len;
  logic          room_pkt, wr_ok, zlp_ok, push, ack_fire, mem_re;

  // Write acceptance: a word needs a free slot and a free queue entry.
  assign room_pkt = (pkt_count < MAX_CNT);
  assign wr_ok    = wr_valid && (used_q < FULL_W) && room_pkt;
  assign zlp_ok   = wr_zlp && !wr_valid && room_pkt;
  assign push     = (wr_ok && wr_last) || zlp_ok;
  assign push_len = zlp_ok ? '0 : part_q + LW'(1);

  assign free_words = FULL_W - used_q;
  assign head_zlp   = (pkt_count != '0) && (head_len == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr   <= '0;
      part_q   <= '0;
      used_q   <= '0;
      overflow <= 1'b0;
    end else begin
      if (wr_ok) begin
        wr_ptr <= wr_ptr + AW'(1);
        part_q <= wr_last ? '0 : part_q + LW'(1);
      end
      case ({wr_ok, ack_fire})
        2'b10:   used_q <= used_q + LW'(1);
        2'b01:   used_q <= used_q - cur_len;
        2'b11:   used_q <= used_q + LW'(1) - cur_len;
        default: used_q <= used_q;
      endcase
      if ((wr_valid && !wr_ok) || (wr_zlp && !wr_valid && !zlp_ok))
        overflow <= 1'b1;
    end
  end

  txpkt_ram #(.DW(DW), .AW(AW)) u_ram (
    .clk   (clk),
    .we    (wr_ok),
    .waddr (wr_ptr),
    .wdata (wr_data),
    .re    (mem_re),
    .raddr (rd_ptr),
    .rdata (rd_data)
  );

  txpkt_desc_q #(.LW(LW), .ENTRIES(MAX_PKTS), .CW(CW)) u_desc (
    .clk      (clk),
    .rst      (rst),
    .push     (push),
    .push_len (push_len),
    .pop      (ack_fire),
    .head_len (head_len),
    .count    (pkt_count)
  );

  txpkt_rd_ctl #(.AW(AW), .LW(LW)) u_rd (
    .clk      (clk),
    .rst      (rst),
    .in_token (in_token),
    .rd_en    (rd_en),
    .pkt_ack  (pkt_ack),
    .rewind   (rewind),
    .have_pkt (pkt_count != '0),
    .head_len (head_len),
    .active   (active),
    .cur_len  (cur_len),
    .cur_zlp  (cur_zlp),
    .rd_valid (rd_valid),
    .mem_re   (mem_re),
    .rd_ptr   (rd_ptr),
    .ack_fire (ack_fire)
  );
endmodule

// File: rtl/txpkt_fifo_chk.sv
module txpkt_fifo_chk #(
  parameter int DEPTH    = 32,
  parameter int MAX_PKTS = 8,
  localparam int LW = $clog2(DEPTH + 1),
  localparam int CW = $clog2(MAX_PKTS + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_valid,
  input logic          wr_last,
  input logic          wr_zlp,
  input logic          rd_en,
  input logic          pkt_ack,
  input logic          rewind,
  input logic          active,
  input logic          rd_valid,
  input logic          overflow,
  input logic [CW-1:0] pkt_count,
  input logic [LW-1:0] free_words
);
  localparam logic [CW-1:0] MAX_CNT = CW'(MAX_PKTS);
  localparam logic [LW-1:0] FULL_W  = LW'(DEPTH);

  // R9
  pkt_cap_chk: assert property (@(posedge clk) disable iff (rst)
    pkt_count <= MAX_CNT);

  // R11
  free_range_chk: assert property (@(posedge clk) disable iff (rst)
    free_words <= FULL_W);

  // R2
  count_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (pkt_count > $past(pkt_count)) |-> $past((wr_valid && wr_last) || (wr_zlp && !wr_valid)));

  // R5
  read_source_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> ($past(rd_en) && $past(active)));

  // R6
  close_cause_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(active) && !$past(rewind)) |-> $past(pkt_ack));

  // R8
  rewind_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (rewind && active && !wr_valid && !wr_zlp) |=> (!active && $stable(pkt_count) && $stable(free_words)));

  // R10
  sticky_ovf_chk: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);
endmodule

bind txpkt_fifo txpkt_fifo_chk #(.DEPTH(DEPTH), .MAX_PKTS(MAX_PKTS)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .wr_valid   (wr_valid),
  .wr_last    (wr_last),
  .wr_zlp     (wr_zlp),
  .rd_en      (rd_en),
  .pkt_ack    (pkt_ack),
  .rewind     (rewind),
  .active     (active),
  .rd_valid   (rd_valid),
  .overflow   (overflow),
  .pkt_count  (pkt_count),
  .free_words (free_words)
);

// File: tb/txpkt_fifo_bench.sv
module txpkt_fifo_bench;
  localparam int DW = 32, DEPTH = 32, MAXP = 8;
  localparam int LW = $clog2(DEPTH + 1), CW = $clog2(MAXP + 1);

  logic clk = 1'b0, rst = 1'b1;
  logic wr_valid = 0, wr_last = 0, wr_zlp = 0;
  logic in_token = 0, rd_en = 0, pkt_ack = 0, rewind = 0;
  logic [DW-1:0] wr_data = '0;
  logic [LW-1:0] free_words, cur_len;
  logic [CW-1:0] pkt_count;
  logic head_zlp, overflow, active, cur_zlp, rd_valid;
  logic [DW-1:0] rd_data;

  int checks = 0, errs = 0;
  int m_used, m_part, m_cnt;
  bit m_ovf;
  logic [DW-1:0] data_q[$];
  int len_q[$];

  always #4 clk = ~clk;

  txpkt_fifo #(.DW(DW), .DEPTH(DEPTH), .MAX_PKTS(MAXP)) u_txpkt_fifo (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_data(wr_data), .wr_last(wr_last),
    .wr_zlp(wr_zlp), .free_words(free_words), .pkt_count(pkt_count), .head_zlp(head_zlp),
    .overflow(overflow), .in_token(in_token), .rd_en(rd_en), .pkt_ack(pkt_ack),
    .rewind(rewind), .active(active), .cur_len(cur_len), .cur_zlp(cur_zlp),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  function automatic int exp_free();
    return DEPTH - m_used;
  endfunction

  function automatic bit can_take_word();
    return (m_used < DEPTH) && (m_cnt < MAXP);
  endfunction

  task automatic check_levels(string req);
    chk(req, "free_words", free_words, exp_free());
    chk(req, "pkt_count", pkt_count, m_cnt);
    chk(req, "overflow", overflow, m_ovf);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    {wr_valid, wr_last, wr_zlp, in_token, rd_en, pkt_ack, rewind} = '0;
    step(); step();
    chk("R1", "pkt_count in reset", pkt_count, 0);
    rst = 1'b0;
    m_used = 0; m_part = 0; m_cnt = 0; m_ovf = 0;
    data_q.delete(); len_q.delete();
    step();
    check_levels("R1");
    chk("R1", "active", active, 0);
    chk("R1", "rd_valid", rd_valid, 0);
  endtask

  task automatic put_word(logic [DW-1:0] d, bit last);
    bit ok;
    ok = can_take_word();
    wr_valid = 1'b1; wr_data = d; wr_last = last;
    step();
    wr_valid = 1'b0; wr_last = 1'b0;
    if (ok) begin
      m_used++; data_q.push_back(d);
      if (last) begin len_q.push_back(m_part + 1); m_cnt++; m_part = 0; end
      else m_part++;
    end else m_ovf = 1;
    check_levels(last ? "R2" : "R11");
  endtask

  task automatic put_zlp();
    bit ok;
    ok = (m_cnt < MAXP);
    wr_zlp = 1'b1;
    step();
    wr_zlp = 1'b0;
    if (ok) begin len_q.push_back(0); m_cnt++; end
    else m_ovf = 1;
    check_levels("R3");
  endtask

  task automatic put_pkt(int n);
    if (n == 0) put_zlp();
    else for (int i = 0; i < n; i++) put_word($urandom, i == n - 1);
  endtask

  task automatic serve(bit rw, bit early);
    int n;
    in_token = 1'b1;
    step();
    in_token = 1'b0;
    if (m_cnt == 0) begin
      chk("R4", "active on empty token", active, 0);
      return;
    end
    n = len_q[0];
    chk("R4", "active", active, 1);
    chk("R4", "cur_len", cur_len, n);
    chk("R3", "cur_zlp", cur_zlp, n == 0);
    if (early && n > 0) begin
      pkt_ack = 1'b1; step(); pkt_ack = 1'b0;
      chk("R7", "active after early ack", active, 1);
      chk("R7", "pkt_count after early ack", pkt_count, m_cnt);
    end
    for (int i = 0; i < n; i++) begin
      rd_en = 1'b1; step();
      chk("R5", "rd_valid", rd_valid, 1);
      chk("R5", "rd_data", rd_data, data_q[i]);
    end
    rd_en = 1'b1; step(); rd_en = 1'b0;
    chk("R5", "rd_valid past end", rd_valid, 0);
    if (rw) begin
      rewind = 1'b1; pkt_ack = 1'b1; step(); rewind = 1'b0; pkt_ack = 1'b0;
      chk("R8", "active after rewind", active, 0);
      check_levels("R8");
      return;
    end
    pkt_ack = 1'b1; step(); pkt_ack = 1'b0;
    m_cnt--; m_used -= n;
    for (int i = 0; i < n; i++) void'(data_q.pop_front());
    void'(len_q.pop_front());
    chk("R6", "active after ack", active, 0);
    check_levels("R6");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    do_reset();
    // R4: token with nothing queued
    serve(0, 0);
    // R3: zero-length packet, then a three-word packet
    put_zlp();
    chk("R3", "head_zlp", head_zlp, 1);
    put_pkt(3);
    serve(0, 0);
    chk("R3", "head_zlp after zlp drained", head_zlp, 0);
    // R7 and R8: early ack, then rewind, then replay
    serve(1, 1);
    serve(0, 0);
    chk("R6", "pkt_count drained", pkt_count, 0);
    // R9: fill the packet queue, then try more
    for (int i = 0; i < MAXP; i++) put_pkt(i % 2);
    chk("R9", "pkt_count at cap", pkt_count, MAXP);
    put_zlp();
    put_word(32'hA5A5_0001, 1'b1);
    chk("R10", "overflow after cap", overflow, 1);
    for (int i = 0; i < MAXP; i++) serve(0, 0);
    // random mix
    for (int it = 0; it < 80; it++) begin
      int n;
      n = $urandom % 7;
      if (($urandom % 3) != 0 && m_cnt < MAXP && m_used + n <= DEPTH) put_pkt(n);
      else serve(($urandom % 4) == 0, ($urandom % 4) == 0);
    end
    while (m_cnt > 0) serve(0, 0);
    // R10: fill every word with an unfinished packet
    do_reset();
    for (int i = 0; i < DEPTH; i++) put_word(i, 1'b0);
    chk("R11", "free_words when full", free_words, 0);
    chk("R10", "overflow before drop", overflow, 0);
    put_word(32'hDEAD_BEEF, 1'b0);
    put_word(32'hDEAD_BEEF, 1'b0);
    chk("R10", "overflow sticky", overflow, 1);
    do_reset();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule